// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits on the memory side of a multi-requester system. It holds a small word-addressed store and carries out single-word operations on it: plain load and store, exchange, test-and-set, fetch-and-add and compare-and-swap. Every operation reads the addressed word, works out a new value, and conditionally writes it back. All three steps form one sequence that no other request can break into.

Several requesters share the unit. Each one has its own valid/ready request channel carrying an opcode, an address and two operands. A round-robin arbiter picks one waiting requester and keeps that grant for the whole read and write of the operation. The response returns the word as it was before the operation, together with a one-bit flag, on a valid strobe addressed to the requester that issued it.

Software builds locks on top of this unit. A lock word is 0 when free and 1 when taken. Acquiring is a test-and-set whose flag reports that the lock was already held. Releasing is a plain store of 0.

Top module: `rmw_unit`

## Requirements
- R1: After reset every memory word reads 0, no `req_ready` bit is high while no `req_valid` is high, and no `rsp_valid` bit is high.
- R2: A request is accepted in a cycle where both its `req_valid` and `req_ready` bits are high. Exactly three rising edges after the accepting edge, a one-cycle pulse appears on the `rsp_valid` bit of that same requester. At most one `req_ready` bit is high in any cycle, and a `req_ready` bit is never high unless its `req_valid` bit is high.
- R3: Opcode 0 (load) returns the addressed word with flag 0 and leaves memory unchanged. Opcodes 6 and 7 behave exactly as a load.
- R4: Opcode 1 (store) writes operand A, returns the previous word and gives flag 0. A store of 0 releases a lock word.
- R5: Opcode 2 (exchange) writes operand A, returns the previous word and gives flag 0.
- R6: Opcode 3 (test-and-set) writes 1 whatever the old value was, returns the old word, and sets the flag exactly when the old word was nonzero.
- R7: Opcode 4 (fetch-and-add) writes the old word plus operand A, wrapping modulo 2^DW with no overflow indication, returns the old word and gives flag 0.
- R8: Opcode 5 (compare-and-swap) compares the word with operand A. On a match it writes operand B and gives flag 1. On a mismatch memory is unchanged and the flag is 0. In both cases it returns the old word.
- R9: Requester 0 has priority first after reset. When several requesters wait, the grant goes to the first waiting index after the one granted last, wrapping around.
- R10: From an acceptance until its response cycle, no other request is accepted. Concurrent fetch-and-adds to one word from different requesters therefore lose no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Per-requester request valid |
| req_ready | output | NREQ | Per-requester acceptance, one-hot or zero |
| req_op | input | NREQ*3 | Opcode per requester, requester i in bits [3i+2:3i] |
| req_addr | input | NREQ*AW | Word address per requester |
| req_opa | input | NREQ*DW | Operand A per requester (store/exchange value, addend, expected value) |
| req_opb | input | NREQ*DW | Operand B per requester (compare-and-swap new value) |
| rsp_valid | output | NREQ | One-cycle response strobe to the issuing requester |
| rsp_data | output | DW | Word value before the operation |
| rsp_flag | output | 1 | Test-and-set busy indication or compare-and-swap success |

## Verification
The assertions assume that a requester keeps its request fields stable while its valid is high and unaccepted. They also assume it needs no backpressure on responses, since the unit offers none. The stimulus changes request fields only just after a rising edge, and only once the previous request from that requester has been accepted. It always takes each response when it arrives. Contention is produced by two requesters hammering the same word at once. Each requester drops its valid for a cycle between requests, which is the pattern that makes the round-robin order visible.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FADD  = 3'd4,
    OP_CAS   = 3'd5
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/rmw_rr_arb.sv
module rmw_rr_arb #(
  parameter int N  = 2,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gidx,
  output logic          gany
);
  logic [IW-1:0] last_q, last_d;

  // first requester after the last granted one, wrapping around
  always_comb begin
    gany = 1'b0;
    gidx = '0;
    for (int off = 1; off <= N; off++) begin
      if (!gany && req[(int'(last_q) + off) % N]) begin
        gany = 1'b1;
        gidx = IW'((int'(last_q) + off) % N);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (take && gany) last_d = gidx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/rmw_store.sv
module rmw_store #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cell_q <= '0;
      else if (we && (waddr == AW'(w)))     cell_q <= wdata;
    end
    assign words[w] = cell_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  old,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  output logic [DW-1:0]  wdata,
  output logic           we,
  output logic           flag
);
  always_comb begin
    wdata = old;
    we    = 1'b0;
    flag  = 1'b0;
    case (op)
      OP_STORE, OP_SWAP: begin
        wdata = opa;
        we    = 1'b1;
      end
      OP_TAS: begin
        wdata = DW'(1);
        we    = 1'b1;
        flag  = (old != '0);
      end
      OP_FADD: begin
        wdata = old + opa;
        we    = 1'b1;
      end
      OP_CAS: begin
        wdata = opb;
        we    = (old == opa);
        flag  = (old == opa);
      end
      default: ; // load and unused codes: read only
    endcase
  end
endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_valid,
  output logic [NREQ-1:0]      req_ready,
  input  logic [NREQ*OPW-1:0]  req_op,
  input  logic [NREQ*AW-1:0]   req_addr,
  input  logic [NREQ*DW-1:0]   req_opa,
  input  logic [NREQ*DW-1:0]   req_opb,
  output logic [NREQ-1:0]      rsp_valid,
  output logic [DW-1:0]        rsp_data,
  output logic                 rsp_flag
);
  rmw_state_e state_q, state_d;
  logic [IW-1:0]  gidx, own_q;
  logic           gany, accept;
  logic [OPW-1:0] op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  opa_q, opb_q, old_q, rdata;
  logic [DW-1:0]  alu_wdata;
  logic           alu_we, alu_flag;
  logic [NREQ-1:0] rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]  rsp_data_q;
  logic           rsp_flag_q;

  // grant held for the whole sequence: arbiter consulted only when idle
  rmw_rr_arb #(.N(NREQ), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .take(accept),
    .gidx(gidx), .gany(gany)
  );

  rmw_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .raddr(addr_q), .rdata(rdata),
    .we(alu_we && (state_q == ST_WRITE)), .waddr(addr_q), .wdata(alu_wdata)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op(op_q), .old(old_q), .opa(opa_q), .opb(opb_q),
    .wdata(alu_wdata), .we(alu_we), .flag(alu_flag)
  );

  assign accept    = (state_q == ST_IDLE) && gany;
  assign req_ready = accept ? (NREQ'(1) << gidx) : '0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (gany) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_valid_d = '0;
    if (state_q == ST_WRITE) rsp_valid_d = NREQ'(1) << own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else if (accept) begin
      own_q  <= gidx;
      op_q   <= req_op[gidx*OPW +: OPW];
      addr_q <= req_addr[gidx*AW +: AW];
      opa_q  <= req_opa[gidx*DW +: DW];
      opb_q  <= req_opb[gidx*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   old_q <= '0;
    else if (state_q == ST_READ)  old_q <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q <= '0;
      rsp_flag_q <= 1'b0;
    end else if (state_q == ST_WRITE) begin
      rsp_data_q <= old_q;
      rsp_flag_q <= alu_flag;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_flag  = rsp_flag_q;
endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
  parameter int NREQ = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic [NREQ-1:0] rsp_valid
);
  logic acc;
  assign acc = |(req_valid & req_ready);

  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_rsp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##3 (rsp_valid == $past(req_valid & req_ready, 3)));

  p_busy_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (req_ready == '0));

  p_busy_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 (req_ready == '0));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (req_ready == '0));
endmodule

bind rmw_unit rmw_unit_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/rmw_unit_test.sv
module rmw_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 2;
  localparam int AW   = 4;
  localparam int DW   = 16;
  localparam int OPW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NREQ-1:0]     drv_valid;
  logic [OPW-1:0]      drv_op   [NREQ];
  logic [AW-1:0]       drv_addr [NREQ];
  logic [DW-1:0]       drv_opa  [NREQ];
  logic [DW-1:0]       drv_opb  [NREQ];
  logic [NREQ*OPW-1:0] req_op;
  logic [NREQ*AW-1:0]  req_addr;
  logic [NREQ*DW-1:0]  req_opa, req_opb;
  logic [NREQ-1:0]     req_ready, rsp_valid;
  logic [DW-1:0]       rsp_data;
  logic                rsp_flag;

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      req_op[i*OPW +: OPW] = drv_op[i];
      req_addr[i*AW +: AW] = drv_addr[i];
      req_opa[i*DW +: DW]  = drv_opa[i];
      req_opb[i*DW +: DW]  = drv_opb[i];
    end
  end

  rmw_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(drv_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_flag(rsp_flag)
  );

  typedef struct {
    int              due;
    logic [NREQ-1:0] mask;
    logic [DW-1:0]   data;
    logic            flag;
    string           tag;
  } exp_t;

  exp_t          expq[$];
  logic [DW-1:0] mdl [1 << AW];
  int            last_grant;
  int            cyc;
  int            checks, errors;
  bit            done;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [OPW-1:0] op);
    case (op)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) cyc = cyc + 1;

  // reference model, compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        chk(rsp_valid == expq[0].mask, "R2", "rsp_valid", rsp_valid, expq[0].mask);
        chk(rsp_data == expq[0].data, expq[0].tag, "rsp_data", rsp_data, expq[0].data);
        chk(rsp_flag == expq[0].flag, expq[0].tag, "rsp_flag", rsp_flag, expq[0].flag);
        void'(expq.pop_front());
      end else begin
        chk(rsp_valid == '0, "R2", "idle rsp_valid", rsp_valid, 0);
      end

      if (drv_valid == '0)
        chk(req_ready == '0, "R1", "ready without valid", req_ready, 0);

      if (req_ready != '0) begin
        int exp_g;
        int g;
        logic [DW-1:0] old;
        logic          fl;
        exp_t          e;
        if (drv_valid == 2'b11) exp_g = (last_grant == 0) ? 1 : 0;
        else                    exp_g = drv_valid[0] ? 0 : 1;
        chk(req_ready == (NREQ'(1) << exp_g), "R9", "grant", req_ready, NREQ'(1) << exp_g);
        if (expq.size() > 0)
          chk(cyc >= expq[$].due, "R10", "accept while busy", cyc, expq[$].due);
        g = req_ready[1] ? 1 : 0;
        last_grant = g;
        old = mdl[drv_addr[g]];
        fl  = 1'b0;
        case (drv_op[g])
          3'd1, 3'd2: mdl[drv_addr[g]] = drv_opa[g];
          3'd3: begin fl = (old != 0); mdl[drv_addr[g]] = 1; end
          3'd4: mdl[drv_addr[g]] = old + drv_opa[g];
          3'd5: if (old == drv_opa[g]) begin fl = 1'b1; mdl[drv_addr[g]] = drv_opb[g]; end
          default: ;
        endcase
        e.due  = cyc + 3;
        e.mask = NREQ'(1) << g;
        e.data = old;
        e.flag = fl;
        e.tag  = tag_of(drv_op[g]);
        expq.push_back(e);
      end
    end
  end

  task automatic issue(int r, logic [OPW-1:0] op, logic [AW-1:0] a,
                       logic [DW-1:0] x, logic [DW-1:0] y);
    @(posedge clk); #1;
    drv_op[r] = op; drv_addr[r] = a; drv_opa[r] = x; drv_opb[r] = y;
    drv_valid[r] = 1'b1;
    do @(negedge clk); while (!req_ready[r]);
    @(posedge clk); #1;
    drv_valid[r] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; last_grant = NREQ - 1; done = 1'b0;
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    for (int i = 0; i < NREQ; i++) begin
      drv_op[i] = '0; drv_addr[i] = '0; drv_opa[i] = '0; drv_opb[i] = '0;
    end
    drv_valid = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == '0, "R1", "ready in reset", req_ready, 0);
    chk(rsp_valid == '0, "R1", "rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    issue(0, 3'd0, 4'd3, 16'h0, 16'h0);        // R1 reset contents, R3 load
    issue(0, 3'd1, 4'd3, 16'h1234, 16'h0);     // R4 store
    issue(1, 3'd0, 4'd3, 16'h0, 16'h0);        // R3
    issue(1, 3'd2, 4'd3, 16'h00AA, 16'h0);     // R5 exchange
    issue(0, 3'd0, 4'd3, 16'h0, 16'h0);
    issue(0, 3'd3, 4'd5, 16'h0, 16'h0);        // R6 free lock
    issue(1, 3'd3, 4'd5, 16'h0, 16'h0);        // R6 taken lock
    issue(1, 3'd1, 4'd5, 16'h0, 16'h0);        // R4 release
    issue(0, 3'd3, 4'd5, 16'h0, 16'h0);        // R6 reacquire
    issue(0, 3'd4, 4'd6, 16'hFFFF, 16'h0);     // R7
    issue(0, 3'd4, 4'd6, 16'h0002, 16'h0);     // R7 wrap
    issue(1, 3'd0, 4'd6, 16'h0, 16'h0);
    issue(0, 3'd5, 4'd7, 16'h0, 16'h0055);     // R8 match
    issue(1, 3'd5, 4'd7, 16'h0, 16'h0066);     // R8 mismatch
    issue(0, 3'd0, 4'd7, 16'h0, 16'h0);        // R8 memory unchanged
    issue(0, 3'd7, 4'd3, 16'hBEEF, 16'hBEEF);  // R3 unused opcode
    issue(1, 3'd6, 4'd3, 16'hBEEF, 16'hBEEF);  // R3 unused opcode
    issue(0, 3'd0, 4'd3, 16'h0, 16'h0);

    // R9, R10: contention on one word
    fork
      begin
        for (int i = 0; i < 5; i++) issue(0, 3'd4, 4'd8, 16'h0003, 16'h0);
      end
      begin
        for (int i = 0; i < 5; i++) issue(1, 3'd4, 4'd8, 16'h0100, 16'h0);
      end
    join
    issue(0, 3'd0, 4'd8, 16'h0, 16'h0);
    chk(mdl[8] == 16'h050F, "R10", "model sum", mdl[8], 16'h050F);

    // R9 mixed contention: lock race then release
    fork
      issue(0, 3'd3, 4'd9, 16'h0, 16'h0);
      issue(1, 3'd3, 4'd9, 16'h0, 16'h0);
    join
    issue(1, 3'd1, 4'd9, 16'h0, 16'h0);
    issue(1, 3'd3, 4'd9, 16'h0, 16'h0);

    repeat (6) @(posedge clk);
    #1;
    chk(expq.size() == 0, "R2", "responses outstanding", expq.size(), 0);
    finish_run();
  end
endmodule